// File: doc/BRIEF.md
# Triggered Packet Capture Engine

The engine stores one byte-wide packet into a paged SRAM each time it is armed. The host first sets up a destination page, two header-length values and two timeout reload values through a byte register port. It then arms the engine by writing to one of three arming addresses. The chosen address fixes how many bytes the capture may hold before an overrun is declared: a base size, four times the base, or eight times the base for calibration captures. The chosen address also decides which header length applies.

While a capture runs, every accepted byte goes to the next sequential SRAM location. Location zero of the capture sits at the start of the selected page. The capture ends in one of four ways: a byte marked as last, a data timeout (no byte within its window), an event timeout (the whole capture took too long), or an overrun. When it ends, the engine records the offset of the last stored byte and a success flag. The host reads both through three read-only byte registers.

Top module: `pkt_capture_top`

## Requirements
- R1: The configuration registers at addresses 0 (page), 1 (data header length), 2 (calibration header length), 3/4 (event reload low/high byte) and 5/6 (data reload low/high byte) read back what was last written. All of them read 0 after reset.
- R2: A write to address 8, 9 or 10 while idle arms a capture with a limit of 2^BASE_LIM_W, 2^MID_LIM_W or 2^CAL_LIM_W bytes respectively. The written data has no effect. `busy` is high from the cycle after the write.
- R3: The k-th accepted byte (k from 0) appears on the memory port one cycle after acceptance. It is written to address (page << BASE_LIM_W) + k, truncated to the memory address width.
- R4: An accepted byte with `in_last` high ends the capture. The end address becomes that byte's offset. The success flag is 1 only if the stored byte count is at least the header length: address 1 for arming at 8 or 9, address 2 for arming at 10.
- R5: A byte that arrives when the limit is already filled is not written. The capture ends with the success flag 0 and end address limit-1.
- R6: The data timeout restarts on arming and on every accepted byte. It expires DAT_DIV times its 16-bit reload cycles later, and a reload of 0 disables it. Expiry ends the capture with the success flag 0 and the end address at the last stored offset, or 0 if nothing was stored.
- R7: The event timeout starts on arming and works the same way, with EVT_DIV cycles per tick. `busy` falls DIV*reload+1 cycles after the arming edge.
- R8: The end address reads at address 12 (bits 7:0), at address 13 bits 5:0 (bits 13:8), and at address 14 bits 3:0 (bits 17:14). Bit 7 of address 14 is the success flag. All unused bits read 0, and all of these read 0 after reset.
- R9: Arming writes made while `busy` is high are ignored. The running capture keeps its limit, header length and page.
- R10: `cap_done` pulses high for exactly one cycle, in the first cycle in which `busy` is low after a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| in_valid | input | 1 | Incoming byte valid |
| in_data | input | 8 | Incoming byte |
| in_last | input | 1 | Incoming byte is the last of the packet |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | PAGE_W+BASE_LIM_W | SRAM byte address |
| mem_wdata | output | 8 | SRAM write data |
| busy | output | 1 | Capture in progress |
| cap_done | output | 1 | One-cycle pulse when a capture ends |

## Verification
Register reads are combinational, so the bench reads them shortly after a falling edge, in the same cycle. An arming write shows as `busy` one edge later. A stored byte reaches the memory port one edge after the edge that accepts it. The end result, `busy` falling and `cap_done` all update on the edge that takes the last byte or sees the overrun. After a timeout they update one edge after the tick count reaches its reload. The bench drives and samples only on falling edges and counts those edges while `busy` is high, so each timeout's DIV*reload+1 window is compared as an exact count. It also waits two falling edges before reading back the end registers and the memory shadow.

// File: rtl/cap_pkg.sv
// Shared types and register addresses of the packet capture engine.
// Assumes a 4-bit byte register address space.
package cap_pkg;

    typedef enum logic [1:0] {
        LIM_BASE = 2'd0,
        LIM_MID  = 2'd1,
        LIM_CAL  = 2'd2
    } lim_sel_e;

    typedef struct packed {
        logic [7:0]  page;
        logic [7:0]  hdr_data;
        logic [7:0]  hdr_cal;
        logic [15:0] evt_rld;
        logic [15:0] dat_rld;
    } cap_cfg_t;

    localparam logic [3:0] A_PAGE    = 4'd0;
    localparam logic [3:0] A_HDR_DAT = 4'd1;
    localparam logic [3:0] A_HDR_CAL = 4'd2;
    localparam logic [3:0] A_EVT_LO  = 4'd3;
    localparam logic [3:0] A_EVT_HI  = 4'd4;
    localparam logic [3:0] A_DAT_LO  = 4'd5;
    localparam logic [3:0] A_DAT_HI  = 4'd6;
    localparam logic [3:0] A_ARM_B   = 4'd8;
    localparam logic [3:0] A_ARM_M   = 4'd9;
    localparam logic [3:0] A_ARM_C   = 4'd10;
    localparam logic [3:0] A_END_LO  = 4'd12;
    localparam logic [3:0] A_END_MID = 4'd13;
    localparam logic [3:0] A_END_HI  = 4'd14;

    localparam int END_W = 18;

endpackage

// File: rtl/cap_regs.sv
// Host byte register file: configuration storage, arming decode and
// read-back of the latched capture result.
// Assumes one write per cycle; reads are combinational on reg_addr.
module cap_regs
    import cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic [END_W-1:0] end_addr,
    input  logic             end_ok,
    output cap_cfg_t         cfg,
    output logic             arm,
    output lim_sel_e         arm_sel,
    output logic [7:0]       reg_rdata
);

    cap_cfg_t cfg_q;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_PAGE:    cfg_q.page          <= reg_wdata;
                A_HDR_DAT: cfg_q.hdr_data      <= reg_wdata;
                A_HDR_CAL: cfg_q.hdr_cal       <= reg_wdata;
                A_EVT_LO:  cfg_q.evt_rld[7:0]  <= reg_wdata;
                A_EVT_HI:  cfg_q.evt_rld[15:8] <= reg_wdata;
                A_DAT_LO:  cfg_q.dat_rld[7:0]  <= reg_wdata;
                A_DAT_HI:  cfg_q.dat_rld[15:8] <= reg_wdata;
                default:   ;
            endcase
        end
    end

    assign cfg = cfg_q;

    // Arming decode: data value is irrelevant, only the address matters.
    always_comb begin
        arm     = 1'b0;
        arm_sel = LIM_BASE;
        if (reg_wr) begin
            case (reg_addr)
                A_ARM_B: begin arm = 1'b1; arm_sel = LIM_BASE; end
                A_ARM_M: begin arm = 1'b1; arm_sel = LIM_MID;  end
                A_ARM_C: begin arm = 1'b1; arm_sel = LIM_CAL;  end
                default: ;
            endcase
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (reg_addr)
            A_PAGE:    reg_rdata = cfg_q.page;
            A_HDR_DAT: reg_rdata = cfg_q.hdr_data;
            A_HDR_CAL: reg_rdata = cfg_q.hdr_cal;
            A_EVT_LO:  reg_rdata = cfg_q.evt_rld[7:0];
            A_EVT_HI:  reg_rdata = cfg_q.evt_rld[15:8];
            A_DAT_LO:  reg_rdata = cfg_q.dat_rld[7:0];
            A_DAT_HI:  reg_rdata = cfg_q.dat_rld[15:8];
            A_END_LO:  reg_rdata = end_addr[7:0];
            A_END_MID: reg_rdata = {2'b00, end_addr[13:8]};
            A_END_HI:  reg_rdata = {end_ok, 3'b000, end_addr[17:14]};
            default:   reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/cap_timeout.sv
// Tick-based timeout: a prescaler of DIV cycles feeds a 16-bit tick
// counter. The timeout expires when the tick count equals a non-zero
// reload. Assumes DIV >= 1; restart or !run clear both counters.
module cap_timeout #(
    parameter int DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        restart,
    input  logic [15:0] reload,
    output logic        expired
);

    localparam int PRE_W = $clog2(DIV + 1);

    logic [PRE_W-1:0] pre_q;
    logic [15:0]      tick_q;

    // Prescaler and tick counter; both hold once the reload is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (tick_q != reload) begin
            if (pre_q == PRE_W'(DIV - 1)) begin
                pre_q  <= '0;
                tick_q <= tick_q + 16'd1;
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    assign expired = run && (reload != 16'd0) && (tick_q == reload);

endmodule

// File: rtl/cap_ctrl.sv
// Capture controller: arms on request, writes accepted bytes to
// sequential SRAM addresses, ends on last byte, timeout or overrun,
// and latches end offset and success flag.
// Assumes timeouts take precedence over a byte in the same cycle.
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int PAGE_W     = 8,
    parameter int BASE_LIM_W = 14,
    parameter int MID_LIM_W  = 16,
    parameter int CAL_LIM_W  = 17
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         arm,
    input  lim_sel_e                     arm_sel,
    input  logic [7:0]                   cfg_page,
    input  logic [7:0]                   cfg_hdr_data,
    input  logic [7:0]                   cfg_hdr_cal,
    input  logic                         in_valid,
    input  logic [7:0]                   in_data,
    input  logic                         in_last,
    input  logic                         evt_exp,
    input  logic                         dat_exp,
    output logic                         busy,
    output logic                         evt_restart,
    output logic                         dat_restart,
    output logic                         mem_we,
    output logic [PAGE_W+BASE_LIM_W-1:0] mem_addr,
    output logic [7:0]                   mem_wdata,
    output logic [END_W-1:0]             end_addr,
    output logic                         end_ok,
    output logic                         done
);

    localparam int MEM_AW = PAGE_W + BASE_LIM_W;

    logic              busy_q;
    lim_sel_e          sel_q;
    logic [7:0]        hdr_q;
    logic [PAGE_W-1:0] page_q;
    logic [END_W-1:0]  cnt_q;
    logic [END_W-1:0]  limit;
    logic [END_W-1:0]  last_off;
    logic              tmo, full, take, arm_ok;
    logic              mem_we_q;
    logic [MEM_AW-1:0] mem_addr_q;
    logic [7:0]        mem_wdata_q;
    logic [END_W-1:0]  end_addr_q;
    logic              end_ok_q, done_q;

    // Capacity of the running capture, chosen by the arming address.
    always_comb begin
        case (sel_q)
            LIM_MID: limit = END_W'(1) << MID_LIM_W;
            LIM_CAL: limit = END_W'(1) << CAL_LIM_W;
            default: limit = END_W'(1) << BASE_LIM_W;
        endcase
    end

    // Per-cycle decisions of the running capture.
    always_comb begin
        tmo         = evt_exp | dat_exp;
        full        = (cnt_q == limit);
        take        = busy_q && !tmo && in_valid && !full;
        arm_ok      = arm && !busy_q;
        last_off    = (cnt_q == '0) ? '0 : cnt_q - END_W'(1);
        evt_restart = arm_ok;
        dat_restart = arm_ok | take;
    end

    // Memory write port, registered one cycle behind acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we_q    <= 1'b0;
            mem_addr_q  <= '0;
            mem_wdata_q <= '0;
        end else begin
            mem_we_q <= take;
            if (take) begin
                mem_addr_q  <= {page_q, {BASE_LIM_W{1'b0}}} + MEM_AW'(cnt_q);
                mem_wdata_q <= in_data;
            end
        end
    end

    // Capture state: arming, byte counting and end-of-capture latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            sel_q      <= LIM_BASE;
            hdr_q      <= '0;
            page_q     <= '0;
            cnt_q      <= '0;
            end_addr_q <= '0;
            end_ok_q   <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (arm_ok) begin
                busy_q <= 1'b1;
                sel_q  <= arm_sel;
                hdr_q  <= (arm_sel == LIM_CAL) ? cfg_hdr_cal : cfg_hdr_data;
                page_q <= cfg_page[PAGE_W-1:0];
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (tmo) begin
                    busy_q     <= 1'b0;
                    done_q     <= 1'b1;
                    end_ok_q   <= 1'b0;
                    end_addr_q <= last_off;
                end else if (in_valid) begin
                    if (full) begin
                        busy_q     <= 1'b0;
                        done_q     <= 1'b1;
                        end_ok_q   <= 1'b0;
                        end_addr_q <= limit - END_W'(1);
                    end else begin
                        cnt_q <= cnt_q + END_W'(1);
                        if (in_last) begin
                            busy_q     <= 1'b0;
                            done_q     <= 1'b1;
                            end_ok_q   <= ((cnt_q + END_W'(1)) >= END_W'(hdr_q));
                            end_addr_q <= cnt_q;
                        end
                    end
                end
            end
        end
    end

    assign busy      = busy_q;
    assign mem_we    = mem_we_q;
    assign mem_addr  = mem_addr_q;
    assign mem_wdata = mem_wdata_q;
    assign end_addr  = end_addr_q;
    assign end_ok    = end_ok_q;
    assign done      = done_q;

    assert_write_in_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_q |-> $past(busy_q));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    assert_end_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(evt_exp || dat_exp || in_valid));

    assert_arm_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(sel_q) && $stable(hdr_q) && $stable(page_q)));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

endmodule

// File: rtl/pkt_capture_top.sv
// Triggered packet capture engine top: register file, two timeouts with
// their own tick periods, and the capture controller.
// Assumes a synchronous byte-write SRAM port with no back-pressure.
module pkt_capture_top
    import cap_pkg::*;
#(
    parameter int PAGE_W     = 8,
    parameter int BASE_LIM_W = 14,
    parameter int MID_LIM_W  = 16,
    parameter int CAL_LIM_W  = 17,
    parameter int EVT_DIV    = 13000,
    parameter int DAT_DIV    = 102
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [3:0]                   reg_addr,
    input  logic [7:0]                   reg_wdata,
    output logic [7:0]                   reg_rdata,
    input  logic                         in_valid,
    input  logic [7:0]                   in_data,
    input  logic                         in_last,
    output logic                         mem_we,
    output logic [PAGE_W+BASE_LIM_W-1:0] mem_addr,
    output logic [7:0]                   mem_wdata,
    output logic                         busy,
    output logic                         cap_done
);

    cap_cfg_t         cfg;
    logic             arm;
    lim_sel_e         arm_sel;
    logic [END_W-1:0] end_addr;
    logic             end_ok;
    logic             evt_exp, dat_exp, evt_restart, dat_restart;

    cap_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .end_addr  (end_addr),
        .end_ok    (end_ok),
        .cfg       (cfg),
        .arm       (arm),
        .arm_sel   (arm_sel),
        .reg_rdata (reg_rdata)
    );

    cap_timeout #(.DIV(EVT_DIV)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (evt_restart),
        .reload  (cfg.evt_rld),
        .expired (evt_exp)
    );

    cap_timeout #(.DIV(DAT_DIV)) u_dat (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (dat_restart),
        .reload  (cfg.dat_rld),
        .expired (dat_exp)
    );

    cap_ctrl #(
        .PAGE_W     (PAGE_W),
        .BASE_LIM_W (BASE_LIM_W),
        .MID_LIM_W  (MID_LIM_W),
        .CAL_LIM_W  (CAL_LIM_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (arm),
        .arm_sel      (arm_sel),
        .cfg_page     (cfg.page),
        .cfg_hdr_data (cfg.hdr_data),
        .cfg_hdr_cal  (cfg.hdr_cal),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_last      (in_last),
        .evt_exp      (evt_exp),
        .dat_exp      (dat_exp),
        .busy         (busy),
        .evt_restart  (evt_restart),
        .dat_restart  (dat_restart),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .end_addr     (end_addr),
        .end_ok       (end_ok),
        .done         (cap_done)
    );

endmodule

// File: tb/sim_pkt_capture_top.sv
`timescale 1ns/1ps
module sim_pkt_capture_top;

    localparam int PW = 4, BW = 4, MW = 6, CW = 7, EDIV = 5, DDIV = 3;
    localparam int AW = PW + BW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic mem_we, busy, cap_done;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;

    int n_tests = 0, n_fail = 0;
    int wcount = 0, dcount = 0;
    logic [7:0] shadow [0:(1<<AW)-1];

    always #2.5 clk = ~clk;

    pkt_capture_top #(.PAGE_W(PW), .BASE_LIM_W(BW), .MID_LIM_W(MW),
        .CAL_LIM_W(CW), .EVT_DIV(EDIV), .DAT_DIV(DDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
        .cap_done(cap_done));

    // Memory shadow and done-pulse counter, sampled on falling edges.
    always @(negedge clk) begin
        if (mem_we) begin
            shadow[mem_addr] = mem_wdata;
            wcount = wcount + 1;
        end
        if (cap_done) dcount = dcount + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] pat(input int i, input int len);
        return 8'((i * 7 + len * 3 + 1) & 8'hFF);
    endfunction

    task automatic send(input int len, input logic with_last);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1; in_data = pat(i, len);
            in_last = with_last && (i == len - 1);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic read_end(output int ea, output int ok, output int junk);
        logic [7:0] b0, b1, b2;
        rd(4'd12, b0); rd(4'd13, b1); rd(4'd14, b2);
        ea = {b2[3:0], b1[5:0], b0};
        ok = b2[7];
        junk = {b1[7:6], b2[6:4]};
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk); @(negedge clk);
    endtask

    // One capture: arm via address 8+mode, send bytes, check result.
    task automatic run_pkt(input int mode, input int page, input int len,
                           input logic with_last, input int exp_ok,
                           input int exp_end, input int exp_wr, input string req);
        int ea, ok, junk;
        wr(4'd0, 8'(page));
        wcount = 0; dcount = 0;
        wr(4'(8 + mode), 8'(len ^ 8'hA5));
        chk({req, " busy after arm (R2)"}, busy, 1);
        send(len, with_last);
        wait_idle();
        read_end(ea, ok, junk);
        chk({req, " ok flag"}, ok, exp_ok);
        chk({req, " end address (R8)"}, ea, exp_end);
        chk({req, " unused end bits zero (R8)"}, junk, 0);
        chk({req, " write count (R3)"}, wcount, exp_wr);
        chk({req, " done pulses (R10)"}, dcount, 1);
        for (int i = 0; i < exp_wr; i++)
            chk({req, " stored byte (R3)"}, shadow[AW'(page * (1 << BW) + i)], pat(i, len));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        logic [7:0] v;
        int ea, ok, junk, n, lim;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R8 reset state
        for (int a = 0; a < 15; a++) begin
            rd(4'(a), v);
            chk("R1 reset read", v, 0);
        end
        chk("R2 reset busy", busy, 0);
        chk("R3 reset mem_we", mem_we, 0);

        // R1 read-back of every configuration register
        for (int a = 0; a < 7; a++) begin
            wr(4'(a), 8'(8'h31 * (a + 1)));
            rd(4'(a), v);
            chk("R1 read-back", v, 8'(8'h31 * (a + 1)));
        end
        for (int a = 0; a < 7; a++) wr(4'(a), 8'h00);

        // R4 sweeps with in_last, all three limits
        for (int len = 1; len <= (1 << BW); len++)
            run_pkt(0, len % 16, len, 1'b1, 1, len - 1, len, "R4 base");
        for (int len = 1; len <= (1 << MW); len += 9)
            run_pkt(1, (len * 3) % 16, len, 1'b1, 1, len - 1, len, "R4 mid");
        run_pkt(1, 2, 1 << MW, 1'b1, 1, (1 << MW) - 1, 1 << MW, "R4 mid full");
        for (int len = 5; len <= (1 << CW); len += 41)
            run_pkt(2, len % 16, len, 1'b1, 1, len - 1, len, "R4 cal");
        run_pkt(2, 7, 1 << CW, 1'b1, 1, (1 << CW) - 1, 1 << CW, "R4 cal full");

        // R5 overrun on each limit
        for (int m = 0; m < 3; m++) begin
            lim = 1 << ((m == 0) ? BW : (m == 1) ? MW : CW);
            run_pkt(m, 3, lim + 2, 1'b0, 0, lim - 1, lim, "R5 overrun");
        end

        // R4 header length follows arming type
        wr(4'd1, 8'd5); wr(4'd2, 8'd3);
        run_pkt(0, 1, 4, 1'b1, 0, 3, 4, "R4 data hdr short");
        run_pkt(0, 1, 5, 1'b1, 1, 4, 5, "R4 data hdr exact");
        run_pkt(2, 1, 3, 1'b1, 1, 2, 3, "R4 cal hdr exact");
        run_pkt(2, 1, 2, 1'b1, 0, 1, 2, "R4 cal hdr short");
        wr(4'd1, 8'd0); wr(4'd2, 8'd0);

        // R9 arming while busy is ignored (base limit kept)
        wr(4'd0, 8'd4);
        wcount = 0; dcount = 0;
        wr(4'd8, 8'h00);
        wr(4'd10, 8'hFF);
        wr(4'd9, 8'h12);
        send(20, 1'b0);
        wait_idle();
        read_end(ea, ok, junk);
        chk("R9 limit kept end", ea, 15);
        chk("R9 ok", ok, 0);
        chk("R9 writes", wcount, 16);
        chk("R9 done pulses (R10)", dcount, 1);

        // R6 data timeout after two bytes
        wr(4'd5, 8'd4);
        wcount = 0; dcount = 0;
        wr(4'd8, 8'h00);
        send(2, 1'b0);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R6 data timeout window", n, DDIV * 4 + 1);
        @(negedge clk); @(negedge clk);
        read_end(ea, ok, junk);
        chk("R6 end offset", ea, 1);
        chk("R6 ok", ok, 0);
        chk("R6 writes", wcount, 2);
        wr(4'd5, 8'd0);

        // R7 event timeout with no bytes
        wr(4'd3, 8'd3);
        dcount = 0;
        wr(4'd9, 8'h00);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R7 event timeout window", n, EDIV * 3 + 1);
        @(negedge clk); @(negedge clk);
        read_end(ea, ok, junk);
        chk("R7 end offset", ea, 0);
        chk("R7 ok", ok, 0);
        chk("R7 done pulses (R10)", dcount, 1);
        wr(4'd3, 8'd0);

        // R6 reload 0 disables: a capture with a long gap still succeeds
        wcount = 0;
        wr(4'd8, 8'h00);
        repeat (40) @(negedge clk);
        chk("R6 disabled still busy", busy, 1);
        send(3, 1'b1);
        wait_idle();
        read_end(ea, ok, junk);
        chk("R6 disabled ok", ok, 1);
        chk("R6 disabled end", ea, 2);

        summary();
    end

endmodule